// File: doc/BRIEF.md
# Multi-Master Global Exclusive Access Monitor

This block sits on a shared memory port and arbitrates exclusive (load-linked / store-conditional style) accesses coming from several bus masters. For each master it holds a single reservation: a valid bit plus the address of one 4-byte granule. An exclusive read from a master creates or replaces that master's reservation. An exclusive write from a master succeeds only while the reservation still covers the written granule. Writes by other masters to a reserved granule break the reservation.

Every request gets a registered response one cycle later. The response carries an exclusive-okay flag and a write-enable for the memory behind the port. A failed exclusive write returns plain okay and its store is suppressed. When several masters issue in the same cycle, they are handled in a fixed order with master 0 first. Each later master sees the reservation changes made by the earlier ones in that cycle.

Top module: `xmon_global`

## Requirements
- R1: After reset every reservation is invalid and all response outputs are low. An exclusive write issued straight after reset fails.
- R2: An exclusive read (op 2'b01) followed by an exclusive write (op 2'b11) to the same granule from the same master returns rsp_exok=1 and rsp_wen=1 in the cycle after the write request. An exclusive read itself returns rsp_exok=0 and rsp_wen=0.
- R3: Reservations cover a 4-byte granule, which is address bits [ADDR_W-1:2]. An exclusive write to another byte of the reserved granule succeeds. An exclusive write to the adjacent granule fails.
- R4: A failed exclusive write returns rsp_vld=1 with rsp_exok=0 and rsp_wen=0.
- R5: An exclusive write with req_shr=1 removes the issuer's own reservation, whether it passes or fails. A repeated exclusive write then fails.
- R6: An exclusive write with req_shr=0 leaves the issuer's own reservation in place. A repeated exclusive write to the same granule succeeds again.
- R7: A normal write (op 2'b10) with req_shr=1 from a different master to a reserved granule removes that reservation. A master's own normal write keeps its reservation.
- R8: A normal write with req_shr=0 does not affect any reservation. Every normal write returns rsp_wen=1 and rsp_exok=0.
- R9: A successful exclusive write removes the reservations that other masters hold on the same granule in that cycle. Reservations on other granules are kept.
- R10: Requests in the same cycle are applied in ascending master index. A later master observes the reservation changes made by earlier masters in that cycle, and an earlier master is unaffected by later ones.
- R11: A normal read (op 2'b00) changes no reservation. Each master holds one reservation only, so a second exclusive read moves it to the new granule.
- R12: rsp_vld for a master is high exactly in the cycle after that master's req_vld was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | N_MASTERS | Request present, one bit per master |
| req_op | input | 2*N_MASTERS | Per-master op: 00 read, 01 exclusive read, 10 write, 11 exclusive write |
| req_shr | input | N_MASTERS | Per-master shareable attribute of the access |
| req_addr | input | ADDR_W*N_MASTERS | Per-master byte address, master i at bits [i*ADDR_W +: ADDR_W] |
| rsp_vld | output | N_MASTERS | Response present (registered) |
| rsp_exok | output | N_MASTERS | Exclusive-okay; low means plain okay (registered) |
| rsp_wen | output | N_MASTERS | Write enable towards memory (registered) |

## Verification
Each request is applied at the rising edge where it is sampled. Its response flags appear after that same edge, so they are valid one cycle after the request. A reservation change caused by a request first affects the request in the next cycle, or a lower-priority request in the same cycle. The bench drives inputs on the falling edge and reads outputs 1 ns after the rising edge that samples them. Each scenario is a chain of single-cycle requests, and each one is checked right after its own edge.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  typedef enum logic [1:0] {
    OP_RD   = 2'b00,
    OP_EXRD = 2'b01,
    OP_WR   = 2'b10,
    OP_EXWR = 2'b11
  } xm_op_e;
endpackage

// File: rtl/xmon_tag_bank.sv
module xmon_tag_bank #(
  parameter int N  = 4,
  parameter int GW = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    nxt_v,
  input  logic [N*GW-1:0] nxt_g,
  output logic [N-1:0]    cur_v,
  output logic [N*GW-1:0] cur_g
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_v <= '0;
      cur_g <= '0;
    end else begin
      cur_v <= nxt_v;
      cur_g <= nxt_g;
    end
  end
endmodule

// File: rtl/xmon_stage.sv
module xmon_stage
  import xmon_pkg::*;
#(
  parameter int N      = 4,
  parameter int ADDR_W = 32,
  parameter int GB     = 2,
  parameter int IDX    = 0,
  localparam int GW    = ADDR_W - GB
) (
  input  logic              vld,
  input  logic [1:0]        op,
  input  logic              shr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      v_i,
  input  logic [N*GW-1:0]   g_i,
  output logic [N-1:0]      v_o,
  output logic [N*GW-1:0]   g_o,
  output logic              pass,
  output logic              wen
);
  logic [GW-1:0] gran;
  logic          unused_lo;
  xm_op_e        kind;
  logic          own_hit;

  assign gran      = addr[ADDR_W-1:GB];
  assign unused_lo = ^addr[GB-1:0];
  assign kind      = xm_op_e'(op);
  assign own_hit   = v_i[IDX] && (g_i[IDX*GW +: GW] == gran);

  always_comb begin
    v_o  = v_i;
    g_o  = g_i;
    pass = 1'b0;
    wen  = 1'b0;
    if (vld) begin
      case (kind)
        OP_EXRD: begin
          v_o[IDX]            = 1'b1;
          g_o[IDX*GW +: GW]   = gran;
        end
        OP_WR: begin
          wen = 1'b1;
          if (shr) begin
            for (int j = 0; j < N; j++) begin
              if (j != IDX && v_i[j] && g_i[j*GW +: GW] == gran) v_o[j] = 1'b0;
            end
          end
        end
        OP_EXWR: begin
          if (own_hit) begin
            pass = 1'b1;
            wen  = 1'b1;
            for (int j = 0; j < N; j++) begin
              if (j != IDX && v_i[j] && g_i[j*GW +: GW] == gran) v_o[j] = 1'b0;
            end
          end
          if (shr) v_o[IDX] = 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xmon_rsp_reg.sv
module xmon_rsp_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] vld_d,
  input  logic [N-1:0] exok_d,
  input  logic [N-1:0] wen_d,
  output logic [N-1:0] vld_q,
  output logic [N-1:0] exok_q,
  output logic [N-1:0] wen_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      exok_q <= '0;
      wen_q  <= '0;
    end else begin
      vld_q  <= vld_d;
      exok_q <= exok_d & vld_d;
      wen_q  <= wen_d & vld_d;
    end
  end
endmodule

// File: rtl/xmon_global.sv
module xmon_global
  import xmon_pkg::*;
#(
  parameter int N_MASTERS  = 4,
  parameter int ADDR_W     = 32,
  parameter int GRAN_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_MASTERS-1:0]        req_vld,
  input  logic [2*N_MASTERS-1:0]      req_op,
  input  logic [N_MASTERS-1:0]        req_shr,
  input  logic [ADDR_W*N_MASTERS-1:0] req_addr,
  output logic [N_MASTERS-1:0]        rsp_vld,
  output logic [N_MASTERS-1:0]        rsp_exok,
  output logic [N_MASTERS-1:0]        rsp_wen
);
  localparam int GB = $clog2(GRAN_BYTES);
  localparam int GW = ADDR_W - GB;
  localparam int N  = N_MASTERS;

  logic [N-1:0]    cur_v;
  logic [N*GW-1:0] cur_g;
  logic [N-1:0]    v_s [0:N];
  logic [N*GW-1:0] g_s [0:N];
  logic [N-1:0]    pass_c;
  logic [N-1:0]    wen_c;

  assign v_s[0] = cur_v;
  assign g_s[0] = cur_g;

  for (genvar i = 0; i < N; i++) begin : g_chain
    xmon_stage #(
      .N(N), .ADDR_W(ADDR_W), .GB(GB), .IDX(i)
    ) u_stg (
      .vld (req_vld[i]),
      .op  (req_op[2*i +: 2]),
      .shr (req_shr[i]),
      .addr(req_addr[i*ADDR_W +: ADDR_W]),
      .v_i (v_s[i]),
      .g_i (g_s[i]),
      .v_o (v_s[i+1]),
      .g_o (g_s[i+1]),
      .pass(pass_c[i]),
      .wen (wen_c[i])
    );
  end

  xmon_tag_bank #(.N(N), .GW(GW)) u_tags (
    .clk  (clk),
    .rst  (rst),
    .nxt_v(v_s[N]),
    .nxt_g(g_s[N]),
    .cur_v(cur_v),
    .cur_g(cur_g)
  );

  xmon_rsp_reg #(.N(N)) u_rsp (
    .clk   (clk),
    .rst   (rst),
    .vld_d (req_vld),
    .exok_d(pass_c),
    .wen_d (wen_c),
    .vld_q (rsp_vld),
    .exok_q(rsp_exok),
    .wen_q (rsp_wen)
  );

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R2
    exok_needs_tag_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_exok[i] |-> $past(cur_v[i]));
    // R4
    exok_writes_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_exok[i] |-> (rsp_wen[i] && rsp_vld[i]));
    // R5
    shr_exwr_drops_own_chk: assert property (@(posedge clk) disable iff (rst)
      (req_vld[i] && req_op[2*i +: 2] == OP_EXWR && req_shr[i]) |=> !cur_v[i]);
    // R12
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_vld[i] |-> $past(req_vld[i]));
  end
endmodule

// File: tb/xmon_global_tb.sv
module xmon_global_tb;
  localparam int N  = 4;
  localparam int AW = 32;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    req_vld;
  logic [2*N-1:0]  req_op;
  logic [N-1:0]    req_shr;
  logic [AW*N-1:0] req_addr;
  logic [N-1:0]    rsp_vld, rsp_exok, rsp_wen;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  xmon_global #(.N_MASTERS(N), .ADDR_W(AW), .GRAN_BYTES(4)) u_dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_op(req_op),
    .req_shr(req_shr), .req_addr(req_addr),
    .rsp_vld(rsp_vld), .rsp_exok(rsp_exok), .rsp_wen(rsp_wen)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = '0; req_op = '0; req_shr = '0; req_addr = '0;
  endtask

  task automatic put(int m, logic [1:0] op, logic [31:0] a, logic s);
    req_vld[m]          = 1'b1;
    req_op[2*m +: 2]    = op;
    req_shr[m]          = s;
    req_addr[m*AW +: AW] = a;
  endtask

  task automatic fire();
    @(posedge clk); #1;
  endtask

  // one master, one cycle
  task automatic one(int m, logic [1:0] op, logic [31:0] a, logic s);
    idle(); put(m, op, a, s); fire();
  endtask

  task automatic do_reset();
    idle(); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1; rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 vld after reset", rsp_vld, 0);
    check("R1 exok after reset", rsp_exok, 0);
    check("R1 wen after reset", rsp_wen, 0);
    one(0, 2'b11, 32'h10, 1'b1);
    check("R1/R4 vld", rsp_vld[0], 1);
    check("R1/R4 exok", rsp_exok[0], 0);
    check("R4 wen", rsp_wen[0], 0);
  endtask

  task automatic t_basic();
    do_reset();
    one(1, 2'b01, 32'h100, 1'b1);
    check("R2 exrd exok", rsp_exok[1], 0);
    check("R2 exrd wen", rsp_wen[1], 0);
    one(1, 2'b11, 32'h100, 1'b1);
    check("R2 exwr exok", rsp_exok[1], 1);
    check("R2 exwr wen", rsp_wen[1], 1);
  endtask

  task automatic t_granule();
    do_reset();
    one(2, 2'b01, 32'h200, 1'b1);
    one(2, 2'b11, 32'h203, 1'b1);
    check("R3 same granule", rsp_exok[2], 1);
    one(2, 2'b01, 32'h200, 1'b1);
    one(2, 2'b11, 32'h204, 1'b1);
    check("R3 next granule exok", rsp_exok[2], 0);
    check("R3 next granule wen", rsp_wen[2], 0);
  endtask

  task automatic t_own_clear();
    do_reset();
    one(0, 2'b01, 32'h40, 1'b1);
    one(0, 2'b11, 32'h40, 1'b1);
    check("R5 first exwr", rsp_exok[0], 1);
    one(0, 2'b11, 32'h40, 1'b1);
    check("R5 repeat exwr", rsp_exok[0], 0);
    one(0, 2'b01, 32'h40, 1'b0);
    one(0, 2'b11, 32'h40, 1'b0);
    check("R6 first exwr", rsp_exok[0], 1);
    one(0, 2'b11, 32'h40, 1'b0);
    check("R6 repeat exwr", rsp_exok[0], 1);
  endtask

  task automatic t_foreign_write();
    do_reset();
    one(0, 2'b01, 32'h80, 1'b1);
    one(1, 2'b10, 32'h82, 1'b1);
    check("R8 normal write wen", rsp_wen[1], 1);
    check("R8 normal write exok", rsp_exok[1], 0);
    one(0, 2'b11, 32'h80, 1'b1);
    check("R7 foreign shr write breaks", rsp_exok[0], 0);
    one(0, 2'b01, 32'h80, 1'b1);
    one(0, 2'b10, 32'h80, 1'b1);
    one(0, 2'b11, 32'h80, 1'b1);
    check("R7 own write keeps", rsp_exok[0], 1);
    one(0, 2'b01, 32'h80, 1'b1);
    one(1, 2'b10, 32'h80, 1'b0);
    check("R8 nonshr write wen", rsp_wen[1], 1);
    one(0, 2'b11, 32'h80, 1'b1);
    check("R8 nonshr write ignored", rsp_exok[0], 1);
  endtask

  task automatic t_winner_clears();
    do_reset();
    idle(); put(0, 2'b01, 32'h300, 1'b1); put(1, 2'b01, 32'h300, 1'b1);
    put(2, 2'b01, 32'h310, 1'b1); fire();
    one(0, 2'b11, 32'h300, 1'b1);
    check("R9 winner", rsp_exok[0], 1);
    one(1, 2'b11, 32'h300, 1'b1);
    check("R9 loser", rsp_exok[1], 0);
    one(2, 2'b11, 32'h310, 1'b1);
    check("R9 other granule kept", rsp_exok[2], 1);
  endtask

  task automatic t_priority();
    do_reset();
    idle(); put(0, 2'b01, 32'h400, 1'b1); put(1, 2'b01, 32'h400, 1'b1); fire();
    idle(); put(0, 2'b11, 32'h400, 1'b1); put(1, 2'b11, 32'h400, 1'b1); fire();
    check("R10 m0 wins", rsp_exok[0], 1);
    check("R10 m1 loses", rsp_exok[1], 0);
    check("R10 m1 no write", rsp_wen[1], 0);
    idle(); put(0, 2'b10, 32'h500, 1'b1); put(1, 2'b01, 32'h500, 1'b1); fire();
    one(1, 2'b11, 32'h500, 1'b1);
    check("R10 later exrd survives", rsp_exok[1], 1);
    one(2, 2'b01, 32'h600, 1'b1);
    idle(); put(1, 2'b10, 32'h600, 1'b1); put(2, 2'b11, 32'h600, 1'b1); fire();
    check("R10 earlier write seen", rsp_exok[2], 0);
    one(2, 2'b01, 32'h700, 1'b1);
    idle(); put(2, 2'b11, 32'h700, 1'b1); put(3, 2'b10, 32'h700, 1'b1); fire();
    check("R10 later write not seen", rsp_exok[2], 1);
  endtask

  task automatic t_reads();
    do_reset();
    one(0, 2'b01, 32'h900, 1'b1);
    idle(); put(1, 2'b00, 32'h900, 1'b1); put(2, 2'b01, 32'h900, 1'b1); fire();
    check("R11 read no wen", rsp_wen[1], 0);
    one(0, 2'b11, 32'h900, 1'b1);
    check("R11 reads keep tag", rsp_exok[0], 1);
    one(0, 2'b01, 32'hA00, 1'b1);
    one(0, 2'b01, 32'hB00, 1'b1);
    one(0, 2'b11, 32'hA00, 1'b1);
    check("R11 retag moved", rsp_exok[0], 0);
    idle(); fire();
    check("R12 idle no rsp", rsp_vld, 0);
    one(3, 2'b00, 32'h0, 1'b0);
    check("R12 rsp on m3 only", rsp_vld, 4'b1000);
  endtask

  initial begin
    rst = 1'b1;
    req_vld = '0; req_op = '0; req_shr = '0; req_addr = '0;
    t_reset();
    t_basic();
    t_granule();
    t_own_clear();
    t_foreign_write();
    t_winner_clears();
    t_priority();
    t_reads();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule